// File: doc/BRIEF.md
# Initiator Network Interface: OCP Requests to Request/Response Packets

This block sits between one OCP 2.2 master and a packet-switched on-chip network. Each accepted command becomes a request packet. The packet is a header cell, then a necker cell, then, for writes, one data cell per burst beat. The header carries the packet kind, a route to one of four memory targets, the master's pressure level, the burst length and the target address. The necker carries the full target address.

An exclusive read opens a locked path to its target. The next write or non-posted write from the master closes that path. Both packets are marked by their packet kind, so switches along the route can hold and release the path.

On the return side, a response packet is a header followed directly by its data cells. The header is consumed silently. Each data cell becomes one OCP data-valid response. A header-only packet, marked last on its header cell, acknowledges a non-posted write with a single response.

Top module: `ocp_pkt_ni`

## Requirements
- R1: After reset the block is ready to accept a command (`s_cmd_acc`=1), sends no cell (`req_valid`=0), drives `req_press`=0, drives `s_resp`=NULL (0) and is ready for a response header (`rsp_ready`=1).
- R2: The cycle after a command is accepted, the block presents a header cell with `req_first`=1. The header fields are: bits [3:0] packet kind, [5:4] route, [7:6] pressure, [15:8] size equal to `m_burst_len`, [47:16] target address, [63:48] zero.
- R3: The route field equals the two most significant address bits.
- R4: The necker cell follows the header and equals the address zero-extended to 64 bits. For a read it ends the packet (`req_last`=1).
- R5: For a write, one data cell per accepted beat follows the necker, carrying `m_data`. The beat with `m_data_last` ends the packet with `req_last`=1.
- R6: The header pressure field, and `req_press` on every cell of the packet, equal the `m_flag` value sampled at command acceptance. `req_press` is 0 when no packet is in flight.
- R7: The packet kind encodes the command: write 1, read 2, exclusive read (lock) 3, unlocking write 4, non-posted write 5, unlocking non-posted write 6. The first write or non-posted write after an exclusive read unlocks; later writes are plain. OCP command codes used: write 1, read 2, exclusive read 3, non-posted write 5.
- R8: `s_cmd_acc` is low from the acceptance of a command until the last cell of its packet is taken by the network.
- R9: A response header is never shown to the master. Each response data cell drives `s_resp`=DVA (1) with `s_data` equal to the cell, and `s_resp_last`=1 on the final cell.
- R10: A response packet whose header carries `rsp_last`=1 produces exactly one DVA response with `s_resp_last`=1 and `s_data`=0.
- R11: While the network holds `req_ready` low, the presented cell and `req_valid` stay unchanged.
- R12: While `m_resp_acc` is low, the presented response stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_cmd | input | 3 | OCP command |
| m_addr | input | AW | OCP address |
| m_burst_len | input | BLW | OCP burst length in beats |
| m_data | input | DW | OCP write data |
| m_data_valid | input | 1 | Write data valid |
| m_data_last | input | 1 | Last write beat of the burst |
| m_resp_acc | input | 1 | Master accepts the response |
| m_flag | input | PW | Pressure level |
| s_cmd_acc | output | 1 | Command accepted |
| s_data_acc | output | 1 | Write data accepted |
| s_resp | output | 2 | Response code, 0 NULL, 1 DVA |
| s_data | output | DW | Read data |
| s_resp_last | output | 1 | Last response of the burst |
| req_valid | output | 1 | Request cell valid |
| req_cell | output | DW | Request cell |
| req_first | output | 1 | Cell is a header |
| req_last | output | 1 | Cell ends the packet |
| req_press | output | PW | Link pressure |
| req_ready | input | 1 | Network takes the request cell |
| rsp_valid | input | 1 | Response cell valid |
| rsp_cell | input | DW | Response cell |
| rsp_last | input | 1 | Response cell ends the packet |
| rsp_ready | output | 1 | Block takes the response cell |

## Verification
A wrong request-side state shows up within one cell. A skipped or repeated phase changes the next cell the network takes, or the cycle in which `s_cmd_acc` returns. A lost lock bit changes the packet kind of the very next write header. On the response side, a state that leaks the header or drops the header-only acknowledge shows up as an unexpected or missing response on the first handshake after that header. Each of these is compared against a per-cycle model in the bench, under steady flow and under back-pressure on both sides.

// File: rtl/ocp_pkt_ni.sv
module ocp_pkt_ni #(
  parameter int AW  = 32,
  parameter int BLW = 8,
  parameter int PW  = 2,
  parameter int DW  = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     m_cmd,
  input  logic [AW-1:0]  m_addr,
  input  logic [BLW-1:0] m_burst_len,
  input  logic [DW-1:0]  m_data,
  input  logic           m_data_valid,
  input  logic           m_data_last,
  input  logic           m_resp_acc,
  input  logic [PW-1:0]  m_flag,
  output logic           s_cmd_acc,
  output logic           s_data_acc,
  output logic [1:0]     s_resp,
  output logic [DW-1:0]  s_data,
  output logic           s_resp_last,
  output logic           req_valid,
  output logic [DW-1:0]  req_cell,
  output logic           req_first,
  output logic           req_last,
  output logic [PW-1:0]  req_press,
  input  logic           req_ready,
  input  logic           rsp_valid,
  input  logic [DW-1:0]  rsp_cell,
  input  logic           rsp_last,
  output logic           rsp_ready
);
  localparam logic [2:0] C_IDLE = 3'd0, C_WR = 3'd1, C_RDEX = 3'd3, C_WRNP = 3'd5;
  localparam logic [3:0] K_WR = 4'd1, K_RD = 4'd2, K_LOCK = 4'd3,
                         K_WR_UL = 4'd4, K_WRNP = 4'd5, K_WRNP_UL = 4'd6;
  localparam logic [1:0] R_NULL = 2'd0, R_DVA = 2'd1;
  localparam int PAD = DW - 6 - PW - BLW - AW;

  typedef enum logic [1:0] {Q_IDLE, Q_HDR, Q_NECK, Q_DATA} qst_t;
  typedef enum logic [1:0] {P_HDR, P_DATA, P_ACK} pst_t;

  qst_t qst;
  pst_t pst;
  logic           c_wr, locked;
  logic [3:0]     c_kind;
  logic [AW-1:0]  c_addr;
  logic [BLW-1:0] c_len;
  logic [PW-1:0]  c_flag;

  logic accept, is_wr, is_np;
  assign accept = s_cmd_acc && (m_cmd != C_IDLE);
  assign is_np  = (m_cmd == C_WRNP);
  assign is_wr  = (m_cmd == C_WR) || is_np;

  logic [3:0] kind_n;
  always_comb begin
    if (m_cmd == C_RDEX)  kind_n = K_LOCK;
    else if (is_wr)       kind_n = locked ? (is_np ? K_WRNP_UL : K_WR_UL)
                                          : (is_np ? K_WRNP : K_WR);
    else                  kind_n = K_RD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qst    <= Q_IDLE;
      locked <= 1'b0;
      c_wr   <= 1'b0;
      c_kind <= '0;
      c_addr <= '0;
      c_len  <= '0;
      c_flag <= '0;
    end else begin
      case (qst)
        Q_IDLE: if (accept) begin
          qst    <= Q_HDR;
          c_wr   <= is_wr;
          c_kind <= kind_n;
          c_addr <= m_addr;
          c_len  <= m_burst_len;
          c_flag <= m_flag;
          if (m_cmd == C_RDEX) locked <= 1'b1;
          else if (is_wr)      locked <= 1'b0;
        end
        Q_HDR:  if (req_ready) qst <= Q_NECK;
        Q_NECK: if (req_ready) qst <= c_wr ? Q_DATA : Q_IDLE;
        default: if (m_data_valid && req_ready && m_data_last) qst <= Q_IDLE;
      endcase
    end
  end

  logic [DW-1:0] hdr, nck;
  assign hdr = {{PAD{1'b0}}, c_addr, c_len, c_flag, c_addr[AW-1 -: 2], c_kind};
  assign nck = {{(DW-AW){1'b0}}, c_addr};

  assign s_cmd_acc  = (qst == Q_IDLE);
  assign s_data_acc = (qst == Q_DATA) && req_ready;
  assign req_valid  = (qst == Q_HDR) || (qst == Q_NECK) || ((qst == Q_DATA) && m_data_valid);
  assign req_first  = (qst == Q_HDR);
  assign req_last   = ((qst == Q_NECK) && !c_wr) || ((qst == Q_DATA) && m_data_last);
  assign req_press  = (qst == Q_IDLE) ? '0 : c_flag;
  assign req_cell   = (qst == Q_HDR) ? hdr : (qst == Q_NECK) ? nck : m_data;

  always_ff @(posedge clk) begin
    if (!rst_n) pst <= P_HDR;
    else case (pst)
      P_HDR:  if (rsp_valid) pst <= rsp_last ? P_ACK : P_DATA;
      P_DATA: if (rsp_valid && m_resp_acc && rsp_last) pst <= P_HDR;
      default: if (m_resp_acc) pst <= P_HDR;
    endcase
  end

  assign rsp_ready   = (pst == P_HDR) || ((pst == P_DATA) && m_resp_acc);
  assign s_resp      = (((pst == P_DATA) && rsp_valid) || (pst == P_ACK)) ? R_DVA : R_NULL;
  assign s_data      = (pst == P_DATA) ? rsp_cell : '0;
  assign s_resp_last = ((pst == P_DATA) && rsp_valid && rsp_last) || (pst == P_ACK);

  p_hdr_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (req_valid && req_first));
  p_press_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (req_press == $past(m_flag)));
  p_lock_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && m_cmd == C_RDEX) |=> (req_cell[3:0] == K_LOCK));
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !s_cmd_acc);
  p_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && !s_resp_last && rsp_valid && rsp_last && s_resp == R_NULL)
      |=> (s_resp == R_DVA && s_resp_last));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && qst != Q_DATA) |=> (req_valid && $stable(req_cell)));
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pst == P_ACK && !m_resp_acc) |=> (s_resp == R_DVA && s_resp_last));
endmodule

// File: tb/ocp_pkt_ni_bench.sv
module ocp_pkt_ni_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] m_cmd = '0;
  logic [31:0] m_addr = '0;
  logic [7:0] m_burst_len = '0;
  logic [63:0] m_data = '0;
  logic m_data_valid = 1'b0, m_data_last = 1'b0, m_resp_acc = 1'b1;
  logic [1:0] m_flag = '0;
  logic s_cmd_acc, s_data_acc, s_resp_last;
  logic [1:0] s_resp;
  logic [63:0] s_data;
  logic req_valid, req_first, req_last, rsp_ready;
  logic [63:0] req_cell;
  logic [1:0] req_press;
  logic req_ready = 1'b1, rsp_valid = 1'b0, rsp_last = 1'b0;
  logic [63:0] rsp_cell = '0;

  ocp_pkt_ni u_ocp_pkt_ni (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0, stall_q = 0, stall_p = 0, busy = 0, lk = 0;
  logic [63:0] eq_cell[$], er_data[$];
  bit eq_first[$], eq_last[$], er_last[$];
  logic [1:0] eq_press[$];
  string eq_tag[$], er_tag[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [63:0] hdr_f(input logic [3:0] k, input logic [1:0] p,
                                        input logic [7:0] l, input logic [31:0] a);
    return {16'h0, a, l, p, a[31:30], k};
  endfunction

  always @(posedge clk) begin
    cyc++;
    #1;
    req_ready  = stall_q ? (cyc % 4 != 1) : 1'b1;
    m_resp_acc = stall_p ? (cyc % 3 != 0) : 1'b1;
  end

  bit hold_q = 0, hold_p = 0;
  logic [63:0] hold_cell, hold_data;
  always @(negedge clk) if (rst_n) begin
    chk(s_cmd_acc == !busy, "R8 command accept", 64'(s_cmd_acc), 64'(!busy));
    if (!busy) chk(req_press == 2'd0, "R6 idle pressure", 64'(req_press), 64'd0);
    if (hold_q) chk(req_valid && req_cell == hold_cell, "R11 held cell", req_cell, hold_cell);
    hold_q = req_valid && !req_ready;
    hold_cell = req_cell;
    if (hold_p) chk(s_resp == 2'd1 && s_data == hold_data, "R12 held response", s_data, hold_data);
    hold_p = (s_resp != 2'd0) && !m_resp_acc;
    hold_data = s_data;
    if (req_valid && req_ready) begin
      if (eq_cell.size() == 0) chk(0, "R5 unexpected request cell", req_cell, 64'd0);
      else begin
        logic [63:0] c; bit f, l; logic [1:0] p; string t;
        c = eq_cell.pop_front(); f = eq_first.pop_front(); l = eq_last.pop_front();
        p = eq_press.pop_front(); t = eq_tag.pop_front();
        chk(req_cell == c, t, req_cell, c);
        chk(req_first == f && req_last == l, {t, " framing"}, {62'd0, req_first, req_last}, {62'd0, f, l});
        chk(req_press == p, "R6 link pressure", 64'(req_press), 64'(p));
        if (l) busy = 0;
      end
    end
    if (m_cmd != 3'd0 && s_cmd_acc) busy = 1;
    if (s_resp != 2'd0 && m_resp_acc) begin
      if (er_data.size() == 0) chk(0, "R9 unexpected response", s_data, 64'd0);
      else begin
        logic [63:0] d; bit l; string t;
        d = er_data.pop_front(); l = er_last.pop_front(); t = er_tag.pop_front();
        chk(s_resp == 2'd1 && s_data == d, t, s_data, d);
        chk(s_resp_last == l, {t, " last"}, 64'(s_resp_last), 64'(l));
      end
    end
  end

  task automatic issue(input logic [2:0] cmd, input logic [31:0] a, input logic [7:0] n,
                       input logic [1:0] fl, input logic [63:0] db);
    bit wr, np; logic [3:0] k;
    wr = (cmd == 3'd1) || (cmd == 3'd5);
    np = (cmd == 3'd5);
    if (cmd == 3'd3) begin k = 4'd3; lk = 1; end
    else if (wr) begin k = lk ? (np ? 4'd6 : 4'd4) : (np ? 4'd5 : 4'd1); lk = 0; end
    else k = 4'd2;
    eq_cell.push_back(hdr_f(k, fl, n, a)); eq_first.push_back(1); eq_last.push_back(0);
    eq_press.push_back(fl); eq_tag.push_back("R2 R3 R7 header");
    eq_cell.push_back({32'h0, a}); eq_first.push_back(0); eq_last.push_back(!wr);
    eq_press.push_back(fl); eq_tag.push_back("R4 necker");
    if (wr) for (int i = 0; i < n; i++) begin
      eq_cell.push_back(db + 64'(i)); eq_first.push_back(0); eq_last.push_back(i == n - 1);
      eq_press.push_back(fl); eq_tag.push_back("R5 data cell");
    end
    m_cmd = cmd; m_addr = a; m_burst_len = n; m_flag = fl;
    do @(negedge clk); while (!s_cmd_acc);
    @(posedge clk); #1 m_cmd = 3'd0;
    if (wr) begin
      for (int i = 0; i < n; i++) begin
        m_data = db + 64'(i); m_data_valid = 1; m_data_last = (i == n - 1);
        do @(negedge clk); while (!s_data_acc);
        @(posedge clk); #1;
      end
      m_data_valid = 0; m_data_last = 0;
    end
  endtask

  task automatic send_rsp(input int n, input logic [63:0] db);
    if (n == 0) begin er_data.push_back(64'd0); er_last.push_back(1); er_tag.push_back("R10 write ack"); end
    for (int i = 0; i < n; i++) begin
      er_data.push_back(db + 64'(i)); er_last.push_back(i == n - 1); er_tag.push_back("R9 read data");
    end
    rsp_valid = 1; rsp_cell = 64'hFEED_0000_0000_BEEF; rsp_last = (n == 0);
    do @(negedge clk); while (!rsp_ready);
    @(posedge clk); #1;
    for (int i = 0; i < n; i++) begin
      rsp_cell = db + 64'(i); rsp_last = (i == n - 1);
      do @(negedge clk); while (!rsp_ready);
      @(posedge clk); #1;
    end
    rsp_valid = 0; rsp_last = 0;
    if (n == 0) repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    chk(0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(s_cmd_acc == 1 && req_valid == 0, "R1 request side reset", {62'd0, s_cmd_acc, req_valid}, 64'd2);
    chk(s_resp == 2'd0 && rsp_ready == 1, "R1 response side reset", {61'd0, s_resp, rsp_ready}, 64'd1);
    chk(req_press == 2'd0, "R1 reset pressure", 64'(req_press), 64'd0);
    @(posedge clk); #1;
    issue(3'd2, 32'h4000_0100, 8'd4, 2'd1, 64'd0);
    issue(3'd1, 32'hC000_0200, 8'd3, 2'd2, 64'h1000);
    stall_q = 1;
    issue(3'd3, 32'h8000_0010, 8'd1, 2'd3, 64'd0);
    issue(3'd1, 32'h8000_0010, 8'd1, 2'd3, 64'h2000);
    issue(3'd1, 32'h0000_0040, 8'd2, 2'd0, 64'h3000);
    issue(3'd3, 32'h4000_0080, 8'd1, 2'd1, 64'd0);
    issue(3'd5, 32'h4000_0080, 8'd1, 2'd1, 64'h4000);
    issue(3'd5, 32'hC000_0300, 8'd2, 2'd2, 64'h4100);
    stall_q = 0;
    issue(3'd2, 32'h8000_0400, 8'd8, 2'd3, 64'd0);
    send_rsp(4, 64'h5000);
    stall_p = 1;
    send_rsp(2, 64'h6000);
    send_rsp(0, 64'd0);
    send_rsp(3, 64'h7000);
    stall_p = 0;
    send_rsp(0, 64'd0);
    send_rsp(1, 64'h8000);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(eq_cell.size() == 0, "R5 all request cells sent", 64'(eq_cell.size()), 64'd0);
    chk(er_data.size() == 0, "R9 all responses delivered", 64'(er_data.size()), 64'd0);
    finish_run();
  end
endmodule